// File: doc/BRIEF.md
# Backlight Power Sequencing Controller

This controller sits on the system side of an LED backlight converter and brings three control lines up and down in a fixed, safe order: the converter supply enable, the dimming-signal enable and the backlight on/off control. Power-up raises the supply first, then the dimming signal, then the backlight control. Power-down reverses that order. A millisecond timebase, derived from a parameterised number of clock cycles per millisecond, holds each step for a minimum interval before the next step may follow.

A single power request drives the sequence. If the request drops part-way through power-up, the controller joins the shutdown order at the step that matches the rails already raised, and does not jump straight to all-off. The choice between internal and external dimming is captured only while the backlight is dark, and is held constant while it is lit. A high level on the converter's fault line while lit starts the normal shutdown order and sets a sticky fault flag. After shutdown the controller rests with all rails off until a clear pulse arrives while the fault line is low.

Top module: `bl_power_seq`

## Requirements
- R1: During and right after reset, sup_en, dim_en, bl_on, ready and fault_latched are all 0.
- R2: With the controller off and no fault latched, a high pwr_req raises sup_en at the next clock edge while dim_en and bl_on stay 0.
- R3: dim_en rises exactly T_SUP_DIM_MS*CYC_PER_MS cycles after sup_en rises, provided pwr_req stays high.
- R4: bl_on rises exactly T_DIM_BL_MS*CYC_PER_MS cycles after dim_en rises, provided pwr_req stays high. ready is 1 exactly when the backlight is lit.
- R5: When pwr_req drops while lit, bl_on falls at the next edge. dim_en falls T_BL_OFF_MS*CYC_PER_MS cycles later, and sup_en falls T_SUP_DIM_MS*CYC_PER_MS cycles after that.
- R6: When pwr_req drops while only the supply is up, dim_en never rises, and sup_en falls 1+T_SUP_DIM_MS*CYC_PER_MS cycles after the edge that samples the drop.
- R7: When pwr_req drops while supply and dimming are up but the backlight is dark, bl_on never rises. dim_en falls 1+T_BL_OFF_MS*CYC_PER_MS cycles after the drop is sampled, and sup_en falls T_SUP_DIM_MS*CYC_PER_MS cycles after that.
- R8: At all times, bl_on=1 implies dim_en=1, and dim_en=1 implies sup_en=1.
- R9: While bl_on is 0, dim_sel follows dim_sel_in one cycle later (0 selects internal, 1 selects external dimming). While bl_on is 1, dim_sel holds its value.
- R10: A high conv_fault sampled while lit sets fault_latched and clears bl_on at the same next edge. The shutdown then uses the same intervals as R5. Afterwards all rails stay off even though pwr_req is held high.
- R11: In the post-fault rest state, a fault_clr pulse clears fault_latched at the next edge only if conv_fault is low; with conv_fault high the pulse has no effect. After a clear, a held pwr_req starts power-up one edge later.
- R12: conv_fault is ignored when the backlight is not lit: fault_latched stays 0 and power-up continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Request backlight on (1) or off (0) |
| dim_sel_in | input | 1 | Dimming source request: 0 internal, 1 external |
| conv_fault | input | 1 | Converter fault line, high means abnormal |
| fault_clr | input | 1 | Clear pulse for the latched fault |
| sup_en | output | 1 | Converter supply enable |
| dim_en | output | 1 | Dimming signal enable |
| bl_on | output | 1 | Backlight on/off control |
| dim_sel | output | 1 | Held dimming source select |
| ready | output | 1 | Backlight fully lit |
| fault_latched | output | 1 | Sticky converter fault flag |

## Verification
Every rail change is due a fixed number of edges after its cause. The first step after a request change lands one edge after the input is sampled. Each timed step lands exactly N*CYC_PER_MS edges after the previous rail change, where N is that step's millisecond count. Select tracking and fault latching land one edge after the input. The bench drives inputs just after a rising edge, samples one time unit after each rising edge, counts edges until the watched rail reaches the expected level, and compares that count with the figure computed from the parameters. Request drops are swept at several points inside the supply-only and dimming-only phases, and the ordering invariant is monitored on every cycle.

// File: rtl/bl_seq_pkg.sv
package bl_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_SUPPLY_ON = 3'd1,
        ST_DIM_ON    = 3'd2,
        ST_LIT       = 3'd3,
        ST_DIM_OFF   = 3'd4,
        ST_SUP_OFF   = 3'd5,
        ST_FAULT     = 3'd6
    } bl_state_e;

    typedef struct packed {
        logic sup;
        logic dim;
        logic bl;
    } rail_t;

    // Rail levels driven in each state
    function automatic rail_t rails_of(bl_state_e s);
        rail_t r;
        r = '0;
        case (s)
            ST_SUPPLY_ON: r = '{sup: 1'b1, dim: 1'b0, bl: 1'b0};
            ST_DIM_ON:    r = '{sup: 1'b1, dim: 1'b1, bl: 1'b0};
            ST_LIT:       r = '{sup: 1'b1, dim: 1'b1, bl: 1'b1};
            ST_DIM_OFF:   r = '{sup: 1'b1, dim: 1'b1, bl: 1'b0};
            ST_SUP_OFF:   r = '{sup: 1'b1, dim: 1'b0, bl: 1'b0};
            default:      r = '0;
        endcase
        return r;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/bl_ms_timer.sv
module bl_ms_timer #(
    parameter int unsigned CYC_PER_MS = 250000,
    parameter int unsigned MS_W       = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [MS_W-1:0] target_ms,
    output logic            expired
);
    localparam int unsigned PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;
    logic             tick;

    assign tick    = (pre_q == PRE_LAST);
    assign expired = tick && (ms_q == target_ms - MS_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (ms_q != '1) begin
                ms_q <= ms_q + MS_W'(1);
            end
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/bl_seq_fsm.sv
module bl_seq_fsm
    import bl_seq_pkg::*;
#(
    parameter int unsigned MS_W         = 9,
    parameter int unsigned T_SUP_DIM_MS = 100,
    parameter int unsigned T_DIM_BL_MS  = 300,
    parameter int unsigned T_BL_OFF_MS  = 300
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwr_req,
    input  logic            conv_fault,
    input  logic            fault_clr,
    input  logic            expired,
    output logic            restart,
    output logic [MS_W-1:0] target_ms,
    output bl_state_e       state,
    output logic            fault_q
);
    localparam logic [MS_W-1:0] W_SUP_DIM = MS_W'(T_SUP_DIM_MS);
    localparam logic [MS_W-1:0] W_DIM_BL  = MS_W'(T_DIM_BL_MS);
    localparam logic [MS_W-1:0] W_BL_OFF  = MS_W'(T_BL_OFF_MS);

    bl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:       if (pwr_req) state_d = ST_SUPPLY_ON;
            ST_SUPPLY_ON: if (!pwr_req) state_d = ST_SUP_OFF;
                          else if (expired) state_d = ST_DIM_ON;
            ST_DIM_ON:    if (!pwr_req) state_d = ST_DIM_OFF;
                          else if (expired) state_d = ST_LIT;
            ST_LIT:       if (conv_fault || !pwr_req) state_d = ST_DIM_OFF;
            ST_DIM_OFF:   if (expired) state_d = ST_SUP_OFF;
            ST_SUP_OFF:   if (expired) state_d = fault_q ? ST_FAULT : ST_OFF;
            ST_FAULT:     if (fault_clr && !conv_fault) state_d = ST_OFF;
            default:      state_d = ST_OFF;
        endcase
    end

    always_comb begin
        case (state_q)
            ST_DIM_ON:  target_ms = W_DIM_BL;
            ST_DIM_OFF: target_ms = W_BL_OFF;
            default:    target_ms = W_SUP_DIM;
        endcase
    end

    assign restart = (state_d != state_q);
    assign state   = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LIT && conv_fault) begin
                fault_q <= 1'b1;
            end else if (state_q == ST_FAULT && fault_clr && !conv_fault) begin
                fault_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bl_sel_latch.sv
module bl_sel_latch (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic sel_in,
    output logic sel_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_out <= 1'b0;
        end else if (!hold) begin
            sel_out <= sel_in;
        end
    end
endmodule

// File: rtl/bl_power_seq.sv
module bl_power_seq
    import bl_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_MS   = 250000,
    parameter int unsigned T_SUP_DIM_MS = 100,
    parameter int unsigned T_DIM_BL_MS  = 300,
    parameter int unsigned T_BL_OFF_MS  = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_req,
    input  logic dim_sel_in,
    input  logic conv_fault,
    input  logic fault_clr,
    output logic sup_en,
    output logic dim_en,
    output logic bl_on,
    output logic dim_sel,
    output logic ready,
    output logic fault_latched
);
    localparam int unsigned MAX_MS = max3(T_SUP_DIM_MS, T_DIM_BL_MS, T_BL_OFF_MS);
    localparam int unsigned MS_W   = $clog2(MAX_MS + 1);

    logic            restart;
    logic            expired;
    logic [MS_W-1:0] target_ms;
    bl_state_e       state;
    rail_t           rails;

    bl_ms_timer #(
        .CYC_PER_MS (CYC_PER_MS),
        .MS_W       (MS_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .target_ms (target_ms),
        .expired   (expired)
    );

    bl_seq_fsm #(
        .MS_W         (MS_W),
        .T_SUP_DIM_MS (T_SUP_DIM_MS),
        .T_DIM_BL_MS  (T_DIM_BL_MS),
        .T_BL_OFF_MS  (T_BL_OFF_MS)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwr_req    (pwr_req),
        .conv_fault (conv_fault),
        .fault_clr  (fault_clr),
        .expired    (expired),
        .restart    (restart),
        .target_ms  (target_ms),
        .state      (state),
        .fault_q    (fault_latched)
    );

    assign rails  = rails_of(state);
    assign sup_en = rails.sup;
    assign dim_en = rails.dim;
    assign bl_on  = rails.bl;
    assign ready  = (state == ST_LIT);

    bl_sel_latch u_sel (
        .clk     (clk),
        .rst     (rst),
        .hold    (state == ST_LIT),
        .sel_in  (dim_sel_in),
        .sel_out (dim_sel)
    );
endmodule

// File: rtl/bl_power_seq_chk.sv
module bl_power_seq_chk (
    input logic clk,
    input logic rst,
    input logic conv_fault,
    input logic sup_en,
    input logic dim_en,
    input logic bl_on,
    input logic dim_sel,
    input logic ready,
    input logic fault_latched
);
    // R8
    bl_needs_dim_chk: assert property (@(posedge clk) disable iff (rst)
        bl_on |-> (dim_en && sup_en));

    // R8
    dim_needs_sup_chk: assert property (@(posedge clk) disable iff (rst)
        dim_en |-> sup_en);

    // R2
    sup_rise_alone_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sup_en) |-> (!dim_en && !bl_on));

    // R3
    dim_after_sup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dim_en) |-> ($past(sup_en) && !bl_on));

    // R4
    bl_after_dim_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bl_on) |-> $past(dim_en));

    // R4
    ready_lit_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> bl_on);

    // R5
    dim_fall_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dim_en) |-> ($past(!bl_on) && sup_en));

    // R9
    sel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (bl_on && $past(bl_on)) |-> $stable(dim_sel));

    // R10
    fault_trip_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bl_on) && $past(conv_fault)) |-> (fault_latched && !bl_on));

    // R10
    fault_dark_chk: assert property (@(posedge clk) disable iff (rst)
        fault_latched |-> !bl_on);

    // R12
    fault_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_latched) |-> ($past(bl_on) && $past(conv_fault)));
endmodule

bind bl_power_seq bl_power_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .conv_fault    (conv_fault),
    .sup_en        (sup_en),
    .dim_en        (dim_en),
    .bl_on         (bl_on),
    .dim_sel       (dim_sel),
    .ready         (ready),
    .fault_latched (fault_latched)
);

// File: tb/tb_bl_power_seq.sv
`timescale 1ns/1ps
module tb_bl_power_seq;
    localparam int C  = 4;
    localparam int S  = 3;
    localparam int D  = 5;
    localparam int O  = 4;
    localparam int SC = S * C;
    localparam int DC = D * C;
    localparam int OC = O * C;

    localparam int W_SUP = 0;
    localparam int W_DIM = 1;
    localparam int W_BL  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req = 1'b0, dim_sel_in = 1'b0, conv_fault = 1'b0, fault_clr = 1'b0;
    logic sup_en, dim_en, bl_on, dim_sel, ready, fault_latched;

    int tests = 0;
    int fails = 0;
    int order_bad = 0;
    bit done = 1'b0;
    bit dim_seen = 1'b0;
    bit bl_seen = 1'b0;

    always #2 clk = ~clk;

    bl_power_seq #(
        .CYC_PER_MS   (C),
        .T_SUP_DIM_MS (S),
        .T_DIM_BL_MS  (D),
        .T_BL_OFF_MS  (O)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .pwr_req       (pwr_req),
        .dim_sel_in    (dim_sel_in),
        .conv_fault    (conv_fault),
        .fault_clr     (fault_clr),
        .sup_en        (sup_en),
        .dim_en        (dim_en),
        .bl_on         (bl_on),
        .dim_sel       (dim_sel),
        .ready         (ready),
        .fault_latched (fault_latched)
    );

    // R8 ordering monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if ((bl_on && !dim_en) || (dim_en && !sup_en)) order_bad++;
            if (ready != bl_on) order_bad++;
            if (dim_en) dim_seen = 1'b1;
            if (bl_on) bl_seen = 1'b1;
        end
    end

    function automatic logic sig(input int w);
        case (w)
            W_SUP:   return sup_en;
            W_DIM:   return dim_en;
            default: return bl_on;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic edges_until(input int w, input logic lvl, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (sig(w) !== lvl && n < 3000);
    endtask

    initial begin
        int n;
        repeat (3) step();
        chk("R1 reset rails", {sup_en, dim_en, bl_on, ready, fault_latched}, 0);
        rst = 1'b0;
        step();
        chk("R1 after reset", {sup_en, dim_en, bl_on, ready, fault_latched}, 0);

        // Full cycles with both dimming sources
        for (int sel = 0; sel < 2; sel++) begin
            dim_sel_in = sel[0];
            step();
            chk("R9 select tracks while dark", dim_sel, sel);
            pwr_req = 1'b1;
            edges_until(W_SUP, 1'b1, n);
            chk("R2 supply rise delay", n, 1);
            chk("R2 dim still low", dim_en, 0);
            edges_until(W_DIM, 1'b1, n);
            chk("R3 dim rise delay", n, SC);
            edges_until(W_BL, 1'b1, n);
            chk("R4 backlight rise delay", n, DC);
            chk("R4 ready when lit", ready, 1);
            dim_sel_in = ~sel[0];
            repeat (5) step();
            chk("R9 select frozen while lit", dim_sel, sel);
            pwr_req = 1'b0;
            edges_until(W_BL, 1'b0, n);
            chk("R5 backlight fall delay", n, 1);
            chk("R4 ready drops", ready, 0);
            edges_until(W_DIM, 1'b0, n);
            chk("R5 dim fall delay", n, OC);
            edges_until(W_SUP, 1'b0, n);
            chk("R5 supply fall delay", n, SC);
            chk("R9 select follows after dark", dim_sel, 1 - sel);
        end

        // Request drop while only the supply is up
        for (int k = 1; k < SC; k += 5) begin
            pwr_req = 1'b1;
            edges_until(W_SUP, 1'b1, n);
            repeat (k) step();
            dim_seen = 1'b0;
            pwr_req = 1'b0;
            edges_until(W_SUP, 1'b0, n);
            chk("R6 supply fall after early drop", n, 1 + SC);
            chk("R6 dim never rose", int'(dim_seen), 0);
        end

        // Request drop while dimming is up but backlight dark
        for (int k = 0; k < DC - 1; k += 7) begin
            pwr_req = 1'b1;
            edges_until(W_DIM, 1'b1, n);
            repeat (k) step();
            bl_seen = 1'b0;
            pwr_req = 1'b0;
            edges_until(W_DIM, 1'b0, n);
            chk("R7 dim fall after drop", n, 1 + OC);
            edges_until(W_SUP, 1'b0, n);
            chk("R7 supply fall", n, SC);
            chk("R7 backlight never rose", int'(bl_seen), 0);
        end

        // Fault while not lit is ignored
        pwr_req = 1'b1;
        edges_until(W_DIM, 1'b1, n);
        conv_fault = 1'b1;
        step();
        conv_fault = 1'b0;
        chk("R12 no latch before lit", fault_latched, 0);
        edges_until(W_BL, 1'b1, n);
        chk("R12 power-up continues", n, DC - 1);

        // Fault while lit
        conv_fault = 1'b1;
        edges_until(W_BL, 1'b0, n);
        chk("R10 backlight trips", n, 1);
        chk("R10 flag set", fault_latched, 1);
        edges_until(W_DIM, 1'b0, n);
        chk("R10 dim fall", n, OC);
        edges_until(W_SUP, 1'b0, n);
        chk("R10 supply fall", n, SC);
        repeat (20) step();
        chk("R10 stays dark with request held", {sup_en, dim_en, bl_on}, 0);
        chk("R10 flag held", fault_latched, 1);

        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        chk("R11 clear ignored with fault high", fault_latched, 1);
        step();
        chk("R11 still dark", sup_en, 0);
        conv_fault = 1'b0;
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        chk("R11 flag cleared", fault_latched, 0);
        edges_until(W_SUP, 1'b1, n);
        chk("R11 restart after clear", n, 1);
        pwr_req = 1'b0;
        edges_until(W_SUP, 1'b0, n);

        chk("R8 ordering violations", order_bad, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule